// File: doc/BRIEF.md
# Lockable One-Time Security Register

This block holds a 128-bit security register made of two 64-bit halves behind a small command interface driven by bus write cycles. The factory half carries a fixed identifier, given as a parameter, and no command can change it. The user half starts erased, all ones, and can only have bits cleared. Clearing happens through a four-write program command. A four-write lock command freezes the user half for good.

The register is hidden in normal mode. A three-write entry command switches the block into identification mode. In that mode ordinary read cycles return the halves and a lock status word. A three-write exit command switches the block back. Every command begins with the same two unlock writes (address `UNL_ADDR1` with data `UNL_DATA1`, then `UNL_ADDR2` with `UNL_DATA2`). The third write goes to `UNL_ADDR1` and carries the command code. All codes and addresses are parameters.

In identification mode the read map is as follows. The status word sits at `STAT_ADDR` (default 0x080). The factory half occupies words `FAC_BASE`..`FAC_BASE+3` (default 0x081–0x084), and the user half occupies `USR_BASE`..`USR_BASE+3` (default 0x085–0x088). Word k holds bits 16k+15..16k of its half.

Top module: `prot_reg_top`

## Requirements
- R1: After reset the block is in normal mode, `rdata` is 0, `locked` equals `LOCK_INIT` (default 0) and the user half equals `USR_INIT` (default all ones).
- R2: After the entry sequence (third write data `CODE_ENTER`, default 0x0090), a read of factory word k returns bits 16k+15..16k of `FACTORY_ID`. Read data appears on `rdata` after the clock edge that samples `rd_en` and holds until the next read.
- R3: In normal mode every read returns 0.
- R4: After the exit sequence (third write data `CODE_EXIT`, default 0x00F0), reads return 0 again.
- R5: A program sequence (third write data `CODE_PROG`, default 0x00C0) followed by a fourth write to user word k ANDs that write's data into word k, so bits can only be cleared.
- R6: If the fourth program write targets any address outside the user words, including the factory words, nothing changes.
- R7: A lock sequence (third write data `CODE_LOCK`, default 0x00C4) followed by a fourth write, to any address, sets the lock when data bit 1 of that write is 0. When bit 1 is 1 nothing changes. All other data bits of that write are ignored.
- R8: In identification mode, a read of `STAT_ADDR` returns bit 1 = 1 while unlocked and 0 when locked, with all other bits 0. The `locked` output is 1 from the edge that samples the locking write.
- R9: Once locked, program sequences leave the user half unchanged.
- R10: A write that does not match the expected address and data of the second or third command cycle ends the sequence without any effect. Idle cycles between command writes do not break a sequence.
- R11: The lock cannot be cleared by any command sequence, including exit and re-entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write cycle strobe |
| rd_en | input | 1 | Read cycle strobe |
| addr | input | 12 | Word address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| locked | output | 1 | High when the user half is locked |

## Verification
A mode change takes effect at the rising edge that samples the third command write. The user half and the lock flag change at the edge that samples the fourth write. Read data is registered, so it is valid one edge after `rd_en` is sampled. The bench drives each write or read on a falling edge, removes it on the next falling edge, and compares `rdata` and `locked` at that point, which is half a cycle after the edge that produced them.

// File: rtl/prot_reg_pkg.sv
package prot_reg_pkg;

    localparam int HALF_BITS = 64;
    localparam int WORD_BITS = 16;
    localparam int HALF_WORDS = HALF_BITS / WORD_BITS;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_GOT1,
        SQ_GOT2,
        SQ_PROG,
        SQ_LOCK
    } seq_st_e;

    typedef struct packed {
        logic enter;
        logic leave;
        logic prog;
        logic lock;
    } fire_t;

endpackage

// File: rtl/prot_cmd_seq.sv
module prot_cmd_seq
    import prot_reg_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int unsigned UNL_ADDR1  = 12'h555,
    parameter int unsigned UNL_ADDR2  = 12'h2AA,
    parameter logic [15:0] UNL_DATA1  = 16'h00AA,
    parameter logic [15:0] UNL_DATA2  = 16'h0055,
    parameter logic [15:0] CODE_ENTER = 16'h0090,
    parameter logic [15:0] CODE_EXIT  = 16'h00F0,
    parameter logic [15:0] CODE_PROG  = 16'h00C0,
    parameter logic [15:0] CODE_LOCK  = 16'h00C4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output fire_t             fire,
    output logic              id_mode
);

    localparam logic [ADDR_W-1:0] A1 = ADDR_W'(UNL_ADDR1);
    localparam logic [ADDR_W-1:0] A2 = ADDR_W'(UNL_ADDR2);

    typedef struct packed {
        seq_st_e st;
        logic    mode;
    } seq_reg_t;

    seq_reg_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        fire = '0;
        if (wr_en) begin
            unique case (r_q.st)
                SQ_IDLE: begin
                    if (addr == A1 && wdata == UNL_DATA1) r_d.st = SQ_GOT1;
                end
                SQ_GOT1: begin
                    r_d.st = (addr == A2 && wdata == UNL_DATA2) ? SQ_GOT2 : SQ_IDLE;
                end
                SQ_GOT2: begin
                    r_d.st = SQ_IDLE;
                    if (addr == A1) begin
                        if (wdata == CODE_ENTER) begin
                            r_d.mode   = 1'b1;
                            fire.enter = 1'b1;
                        end else if (wdata == CODE_EXIT) begin
                            r_d.mode   = 1'b0;
                            fire.leave = 1'b1;
                        end else if (wdata == CODE_PROG) begin
                            r_d.st = SQ_PROG;
                        end else if (wdata == CODE_LOCK) begin
                            r_d.st = SQ_LOCK;
                        end
                    end
                end
                SQ_PROG: begin
                    fire.prog = 1'b1;
                    r_d.st    = SQ_IDLE;
                end
                SQ_LOCK: begin
                    fire.lock = ~wdata[1];
                    r_d.st    = SQ_IDLE;
                end
                default: r_d.st = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= SQ_IDLE;
            r_q.mode <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign id_mode = r_q.mode;

    // R10
    one_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fire.enter, fire.leave, fire.prog, fire.lock}));

    // R4
    leave_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire.leave |=> !id_mode);

endmodule

// File: rtl/prot_usr_store.sv
module prot_usr_store
    import prot_reg_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter int unsigned     USR_BASE  = 12'h085,
    parameter logic [HALF_BITS-1:0] USR_INIT = '1,
    parameter logic            LOCK_INIT = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 prog_fire,
    input  logic                 lock_fire,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [15:0]          wdata,
    output logic [HALF_BITS-1:0] usr_bits,
    output logic                 lock_out
);

    typedef struct packed {
        logic [HALF_WORDS-1:0][WORD_BITS-1:0] words;
        logic                                 lock;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int k = 0; k < HALF_WORDS; k++) begin
            if (prog_fire && !s_q.lock && addr == ADDR_W'(USR_BASE + k)) begin
                s_d.words[k] = s_q.words[k] & wdata;
            end
        end
        if (lock_fire) s_d.lock = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.words <= USR_INIT;
            s_q.lock  <= LOCK_INIT;
        end else begin
            s_q <= s_d;
        end
    end

    assign usr_bits = s_q.words;
    assign lock_out = s_q.lock;

    // R9
    locked_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.lock && prog_fire) |=> $stable(usr_bits));

    // R11
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_out |=> lock_out);

    // R5
    only_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_fire |=> ((usr_bits & ~$past(usr_bits)) == '0));

endmodule

// File: rtl/prot_rd_mux.sv
module prot_rd_mux
    import prot_reg_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int unsigned STAT_ADDR = 12'h080,
    parameter int unsigned FAC_BASE  = 12'h081,
    parameter int unsigned USR_BASE  = 12'h085
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 id_mode,
    input  logic [HALF_BITS-1:0] fac_bits,
    input  logic [HALF_BITS-1:0] usr_bits,
    input  logic                 lock_in,
    output logic [15:0]          rdata
);

    logic [15:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en) begin
            rdata_d = '0;
            if (id_mode) begin
                if (addr == ADDR_W'(STAT_ADDR)) rdata_d[1] = ~lock_in;
                for (int k = 0; k < HALF_WORDS; k++) begin
                    if (addr == ADDR_W'(FAC_BASE + k))
                        rdata_d = fac_bits[k*WORD_BITS +: WORD_BITS];
                    if (addr == ADDR_W'(USR_BASE + k))
                        rdata_d = usr_bits[k*WORD_BITS +: WORD_BITS];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    // R3
    normal_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !id_mode) |=> (rdata == '0));

    // R8
    status_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && id_mode && addr == ADDR_W'(STAT_ADDR)) |=> (rdata[1] == ~lock_in));

endmodule

// File: rtl/prot_reg_top.sv
module prot_reg_top
    import prot_reg_pkg::*;
#(
    parameter int              ADDR_W     = 12,
    parameter logic [HALF_BITS-1:0] FACTORY_ID = 64'h0123_4567_89AB_CDEF,
    parameter logic [HALF_BITS-1:0] USR_INIT   = '1,
    parameter logic            LOCK_INIT  = 1'b0,
    parameter int unsigned     STAT_ADDR  = 12'h080,
    parameter int unsigned     FAC_BASE   = 12'h081,
    parameter int unsigned     USR_BASE   = 12'h085,
    parameter int unsigned     UNL_ADDR1  = 12'h555,
    parameter int unsigned     UNL_ADDR2  = 12'h2AA,
    parameter logic [15:0]     UNL_DATA1  = 16'h00AA,
    parameter logic [15:0]     UNL_DATA2  = 16'h0055,
    parameter logic [15:0]     CODE_ENTER = 16'h0090,
    parameter logic [15:0]     CODE_EXIT  = 16'h00F0,
    parameter logic [15:0]     CODE_PROG  = 16'h00C0,
    parameter logic [15:0]     CODE_LOCK  = 16'h00C4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              locked
);

    fire_t                fire;
    logic                 id_mode;
    logic [HALF_BITS-1:0] usr_bits;
    logic                 lock_w;

    prot_cmd_seq #(
        .ADDR_W(ADDR_W), .UNL_ADDR1(UNL_ADDR1), .UNL_ADDR2(UNL_ADDR2),
        .UNL_DATA1(UNL_DATA1), .UNL_DATA2(UNL_DATA2),
        .CODE_ENTER(CODE_ENTER), .CODE_EXIT(CODE_EXIT),
        .CODE_PROG(CODE_PROG), .CODE_LOCK(CODE_LOCK)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .fire(fire), .id_mode(id_mode)
    );

    prot_usr_store #(
        .ADDR_W(ADDR_W), .USR_BASE(USR_BASE),
        .USR_INIT(USR_INIT), .LOCK_INIT(LOCK_INIT)
    ) store_i (
        .clk(clk), .rst_n(rst_n), .prog_fire(fire.prog), .lock_fire(fire.lock),
        .addr(addr), .wdata(wdata), .usr_bits(usr_bits), .lock_out(lock_w)
    );

    prot_rd_mux #(
        .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR),
        .FAC_BASE(FAC_BASE), .USR_BASE(USR_BASE)
    ) rd_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .id_mode(id_mode),
        .fac_bits(FACTORY_ID), .usr_bits(usr_bits), .lock_in(lock_w),
        .rdata(rdata)
    );

    assign locked = lock_w;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (rdata == '0 && locked == LOCK_INIT));

endmodule

// File: tb/prot_reg_top_tb_top.sv
`timescale 1ns/1ps
module prot_reg_top_tb_top;

    localparam logic [63:0] FID = 64'h0123_4567_89AB_CDEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        locked;

    int checks = 0;
    int fails  = 0;

    logic        m_mode;
    logic        m_lock;
    logic [15:0] m_usr [4];

    always #2.5 clk = ~clk;

    prot_reg_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .locked(locked)
    );

    function automatic logic [15:0] exp_read(input logic [11:0] a);
        if (!m_mode) return 16'h0;
        if (a == 12'h080) return {14'h0, ~m_lock, 1'b0};
        if (a >= 12'h081 && a <= 12'h084) return FID[(a - 12'h081) * 16 +: 16];
        if (a >= 12'h085 && a <= 12'h088) return m_usr[a - 12'h085];
        return 16'h0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, {16'h0, rdata}, {16'h0, exp_read(a)});
        check(req, {31'h0, locked}, {31'h0, m_lock});
    endtask

    task automatic cmd3(input logic [15:0] code);
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0055);
        wr(12'h555, code);
    endtask

    task automatic do_enter();
        cmd3(16'h0090); m_mode = 1'b1;
    endtask

    task automatic do_exit();
        cmd3(16'h00F0); m_mode = 1'b0;
    endtask

    task automatic do_prog(input logic [11:0] a, input logic [15:0] d);
        cmd3(16'h00C0);
        wr(a, d);
        if (!m_lock && a >= 12'h085 && a <= 12'h088) m_usr[a - 12'h085] &= d;
    endtask

    task automatic do_lock(input logic [11:0] a, input logic [15:0] d);
        cmd3(16'h00C4);
        wr(a, d);
        if (!d[1]) m_lock = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        fails++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5EED_1234);
        m_mode = 1'b0; m_lock = 1'b0;
        for (int k = 0; k < 4; k++) m_usr[k] = 16'hFFFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {16'h0, rdata}, 32'h0);
        check("R1", {31'h0, locked}, 32'h0);
        // R3 normal mode hides the register
        rd_chk("R3", 12'h081);
        rd_chk("R3", 12'h080);
        // R2 entry and factory words
        do_enter();
        for (int k = 0; k < 4; k++) rd_chk("R2", 12'h081 + 12'(k));
        // R1 user half erased after reset
        for (int k = 0; k < 4; k++) rd_chk("R1", 12'h085 + 12'(k));
        rd_chk("R8", 12'h080);
        // R5 program clears bits only
        do_prog(12'h086, 16'hF0F0);
        rd_chk("R5", 12'h086);
        do_prog(12'h086, 16'h3FFF);
        rd_chk("R5", 12'h086);
        // R6 factory and stray addresses not writable
        do_prog(12'h082, 16'h0000);
        rd_chk("R6", 12'h082);
        do_prog(12'h089, 16'h0000);
        for (int k = 0; k < 4; k++) rd_chk("R6", 12'h085 + 12'(k));
        // R10 broken second cycle: following command-like write ignored
        do_exit();
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0056);
        wr(12'h555, 16'h0090);
        rd_chk("R10", 12'h081);
        // R10 unknown code then a write to a user word: no program
        do_enter();
        cmd3(16'h0012);
        wr(12'h085, 16'h0000);
        rd_chk("R10", 12'h085);
        // R7 lock with bit1 set does nothing
        do_lock(12'h000, 16'hFFFF);
        rd_chk("R7", 12'h080);
        // constrained random: programs, aborts, mode changes, reads
        for (int n = 0; n < 300; n++) begin
            int op;
            op = int'($urandom_range(0, 5));
            case (op)
                0, 1: do_prog(12'h083 + 12'($urandom_range(0, 6)), 16'($urandom));
                2: if ($urandom_range(0, 1) == 1) do_enter(); else do_exit();
                3: begin
                    wr(12'h555, 16'h00AA);
                    wr(12'h2AA + 12'($urandom_range(1, 3)), 16'h0055);
                    wr(12'h085 + 12'($urandom_range(0, 3)), 16'h0000);
                end
                4: do_lock(12'($urandom), 16'($urandom) | 16'h0002);
                default: rd_chk("R5", 12'h080 + 12'($urandom_range(0, 9)));
            endcase
        end
        do_enter();
        for (int k = 0; k < 4; k++) rd_chk("R5", 12'h085 + 12'(k));
        // R7 lock with bit1 clear, other bits ignored, any address
        do_lock(12'h3C1, 16'hFFFD);
        rd_chk("R8", 12'h080);
        check("R7", {31'h0, locked}, 32'h1);
        // R9 program rejected after lock
        do_prog(12'h087, 16'h0000);
        do_prog(12'h088, 16'h1234);
        for (int k = 0; k < 4; k++) rd_chk("R9", 12'h085 + 12'(k));
        // R11 lock survives exit, re-entry and repeated commands
        do_exit();
        do_lock(12'h000, 16'hFFFF);
        do_enter();
        rd_chk("R11", 12'h080);
        check("R11", {31'h0, locked}, 32'h1);
        // R4 exit hides register again
        do_exit();
        rd_chk("R4", 12'h085);
        rd_chk("R4", 12'h080);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule